// File: doc/BRIEF.md
# Pivot-Table Spare Allocator for Row/Column Redundancy

This block decides, on chip, how a memory's spare rows and spare column groups should be spent. It does this without holding a failure bitmap. A self-test engine streams the addresses of failing cells into it, one row/column pair per strobe. The block keeps a short table of pivot entries, one per fault that matched nothing stored before. An incoming fault that shares a row with an entry marks that entry as needing a spare row. A fault that shares a column group with an entry marks it as needing a spare column group. In both cases the fault is absorbed and no new entry is made.

When the engine signals the end of the test, the block walks the table twice. The first pass serves flagged entries. The second pass serves the unflagged (orthogonal) entries. It then reports whether the memory can be repaired, and which row and column-group addresses each spare should take over. If more distinct faults arrive than there are spares in total, the memory is declared irreparable at once.

A column group spans 2^GROUP_BITS adjacent columns. Only the group part of the column address, `col_addr >> GROUP_BITS`, is ever compared or reported. The table has SPARE_ROWS+SPARE_COLS entries.

Top module: `pivot_redund_alloc`

## Requirements
- R1: After reset or a `start` pulse, `done`, `repairable` and every spare valid flag read 0. Fault strobes and `test_done` seen before the first `start` are ignored.
- R2: A fault whose row matches no stored entry and whose column group matches no stored entry creates a new table entry. If it matches the row of entry i and the column group of a different entry j, both entries are flagged (i for a row spare, j for a column spare) and no entry is created.
- R3: A fault whose row equals a stored entry's row flags that entry for a spare row and creates no entry. Up to SPARE_ROWS such entries are all repaired with spare rows.
- R4: A fault whose group address (`col_addr >> GROUP_BITS`) equals a stored entry's group flags that entry for a spare column group. The low GROUP_BITS column bits take no part in the match.
- R5: A fault whose row and column group both match the same entry changes nothing.
- R6: A fault that would need a new entry while all SPARE_ROWS+SPARE_COLS entries are in use makes `done`=1 with `repairable`=0 on the next cycle. This holds even when it arrives together with `test_done`. Further strobes are ignored until `start`.
- R7: In the first pass, entries are visited in table order. A row-flagged entry takes the lowest free spare row, and a column-flagged entry takes the lowest free spare column group.
- R8: If row-flagged entries outnumber SPARE_ROWS, or column-flagged entries outnumber SPARE_COLS, `repairable` is 0 when `done` rises.
- R9: In the second pass, each unflagged entry, in table order, takes the lowest free spare row. If none is left it takes the lowest free spare column group. If neither is left, `repairable` is 0.
- R10: A fault strobed in the same cycle as `test_done` is included in the allocation.
- R11: Once `done` is 1, it and all spare outputs hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clears the table and begins a collection run |
| fault_valid | input | 1 | Strobe for one failing-cell address |
| row_addr | input | ROW_W | Row of the failing cell |
| col_addr | input | COL_W | Column of the failing cell |
| test_done | input | 1 | Self-test finished; begin allocation |
| done | output | 1 | Result is ready |
| repairable | output | 1 | 1 when every fault is covered (valid with `done`) |
| srow_valid | output | SPARE_ROWS | Bit k set: spare row k is used |
| srow_addr | output | SPARE_ROWS*ROW_W | Row replaced by spare row k, at bits k*ROW_W |
| scol_valid | output | SPARE_COLS | Bit k set: spare column group k is used |
| scol_addr | output | SPARE_COLS*(COL_W-GROUP_BITS) | Group replaced by spare group k, at bits k*(COL_W-GROUP_BITS) |

## Verification
The end-of-test signal can coincide with the last fault strobe, including a strobe that overflows the table. In that cycle, collection, the overflow decision and the hand-off to allocation all act together. The bench drives a single fault with `test_done` high and judges that the fault shows up as spare row 0. It also drives the seventh distinct fault together with `test_done` and judges that `done` rises one cycle later with `repairable` low, rather than an allocation result appearing.

// File: rtl/pivot_redund_alloc.sv
module pivot_redund_alloc #(
  parameter int ROW_W      = 8,
  parameter int COL_W      = 6,
  parameter int GROUP_BITS = 2,
  parameter int SPARE_ROWS = 4,
  parameter int SPARE_COLS = 2
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        start,
  input  logic                                        fault_valid,
  input  logic [ROW_W-1:0]                            row_addr,
  input  logic [COL_W-1:0]                            col_addr,
  input  logic                                        test_done,
  output logic                                        done,
  output logic                                        repairable,
  output logic [SPARE_ROWS-1:0]                       srow_valid,
  output logic [SPARE_ROWS*ROW_W-1:0]                 srow_addr,
  output logic [SPARE_COLS-1:0]                       scol_valid,
  output logic [SPARE_COLS*(COL_W-GROUP_BITS)-1:0]    scol_addr
);
  localparam int GC_W  = COL_W - GROUP_BITS;
  localparam int ENT   = SPARE_ROWS + SPARE_COLS;
  localparam int IDX_W = $clog2(ENT);
  localparam int CNT_W = $clog2(ENT + 1);
  localparam int NR_W  = $clog2(SPARE_ROWS + 1);
  localparam int NC_W  = $clog2(SPARE_COLS + 1);
  localparam int RI_W  = $clog2(SPARE_ROWS);
  localparam int CI_W  = $clog2(SPARE_COLS);
  localparam logic [CNT_W-1:0] ENT_N  = CNT_W'(ENT);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(ENT - 1);
  localparam logic [NR_W-1:0]  SR_N   = NR_W'(SPARE_ROWS);
  localparam logic [NC_W-1:0]  SC_N   = NC_W'(SPARE_COLS);

  typedef enum logic [1:0] {S_IDLE, S_COLL, S_ALLOC, S_DONE} st_t;

  st_t               st;
  logic [ROW_W-1:0]  prow [ENT];
  logic [GC_W-1:0]   pcol [ENT];
  logic [ENT-1:0]    pv, rf, cf;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic              ph, fail;
  logic [NR_W-1:0]   nr;
  logic [NC_W-1:0]   nc;
  logic [ROW_W-1:0]  sr_a [SPARE_ROWS];
  logic [GC_W-1:0]   sc_a [SPARE_COLS];

  logic [GC_W-1:0]   gcol;
  logic [ENT-1:0]    row_hit, col_hit;
  logic              any_hit, same_cell, coll_ovf, absorb;

  assign gcol = GC_W'(col_addr >> GROUP_BITS);

  for (genvar i = 0; i < ENT; i++) begin : g_cmp
    assign row_hit[i] = pv[i] && (prow[i] == row_addr);
    assign col_hit[i] = pv[i] && (pcol[i] == gcol);
  end

  assign any_hit   = |(row_hit | col_hit);
  assign same_cell = |(row_hit & col_hit);
  assign coll_ovf  = (st == S_COLL) && fault_valid && !any_hit && (cnt == ENT_N);
  assign absorb    = (st == S_COLL) && fault_valid && any_hit;

  assign done       = (st == S_DONE);
  assign repairable = done && !fail;

  for (genvar k = 0; k < SPARE_ROWS; k++) begin : g_sro
    assign srow_valid[k] = NR_W'(k) < nr;
    assign srow_addr[k*ROW_W +: ROW_W] = sr_a[k];
  end
  for (genvar k = 0; k < SPARE_COLS; k++) begin : g_sco
    assign scol_valid[k] = NC_W'(k) < nc;
    assign scol_addr[k*GC_W +: GC_W] = sc_a[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      st   <= rst_n ? S_COLL : S_IDLE;
      pv   <= '0;
      rf   <= '0;
      cf   <= '0;
      cnt  <= '0;
      idx  <= '0;
      ph   <= 1'b0;
      fail <= 1'b0;
      nr   <= '0;
      nc   <= '0;
      for (int i = 0; i < ENT; i++) begin
        prow[i] <= '0;
        pcol[i] <= '0;
      end
      for (int k = 0; k < SPARE_ROWS; k++) sr_a[k] <= '0;
      for (int k = 0; k < SPARE_COLS; k++) sc_a[k] <= '0;
    end else begin
      case (st)
        S_COLL: begin
          if (test_done) begin
            st  <= S_ALLOC;
            idx <= '0;
            ph  <= 1'b0;
          end
          if (fault_valid && !same_cell) begin
            if (any_hit) begin
              rf <= rf | row_hit;
              cf <= cf | col_hit;
            end else if (cnt == ENT_N) begin
              fail <= 1'b1;
              st   <= S_DONE;
            end else begin
              prow[cnt[IDX_W-1:0]] <= row_addr;
              pcol[cnt[IDX_W-1:0]] <= gcol;
              pv[cnt[IDX_W-1:0]]   <= 1'b1;
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_ALLOC: begin
          if (!ph) begin
            if (pv[idx] && rf[idx]) begin
              if (nr < SR_N) begin
                sr_a[nr[RI_W-1:0]] <= prow[idx];
                nr <= nr + 1'b1;
              end else fail <= 1'b1;
            end
            if (pv[idx] && cf[idx]) begin
              if (nc < SC_N) begin
                sc_a[nc[CI_W-1:0]] <= pcol[idx];
                nc <= nc + 1'b1;
              end else fail <= 1'b1;
            end
          end else if (pv[idx] && !rf[idx] && !cf[idx]) begin
            if (nr < SR_N) begin
              sr_a[nr[RI_W-1:0]] <= prow[idx];
              nr <= nr + 1'b1;
            end else if (nc < SC_N) begin
              sc_a[nc[CI_W-1:0]] <= pcol[idx];
              nc <= nc + 1'b1;
            end else fail <= 1'b1;
          end
          if (idx == LAST_I) begin
            idx <= '0;
            ph  <= 1'b1;
            if (ph) st <= S_DONE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module pivot_redund_alloc_chk #(
  parameter int SR_VW = 4,
  parameter int SC_VW = 2,
  parameter int SR_AW = 32,
  parameter int SC_AW = 8,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic             repairable,
  input logic [SR_VW-1:0] srow_valid,
  input logic [SC_VW-1:0] scol_valid,
  input logic [SR_AW-1:0] srow_addr,
  input logic [SC_AW-1:0] scol_addr,
  input logic             coll_ovf,
  input logic             absorb,
  input logic [CW-1:0]    cnt
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && srow_valid == '0 && scol_valid == '0)); // R1
  AST_OVERFLOW_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_ovf && !start) |=> (done && !repairable)); // R6
  AST_ABSORB_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (absorb && !start) |=> $stable(cnt)); // R3
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(repairable))); // R11
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(srow_valid) && $stable(scol_valid) &&
                          $stable(srow_addr) && $stable(scol_addr))); // R11
endmodule

bind pivot_redund_alloc pivot_redund_alloc_chk #(
  .SR_VW(SPARE_ROWS), .SC_VW(SPARE_COLS),
  .SR_AW(SPARE_ROWS*ROW_W), .SC_AW(SPARE_COLS*(COL_W-GROUP_BITS)),
  .CW($clog2(SPARE_ROWS+SPARE_COLS+1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .repairable(repairable),
  .srow_valid(srow_valid), .scol_valid(scol_valid),
  .srow_addr(srow_addr), .scol_addr(scol_addr),
  .coll_ovf(coll_ovf), .absorb(absorb), .cnt(cnt)
);

// File: tb/tb_pivot_redund_alloc.sv
module tb_pivot_redund_alloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        fault_valid = 1'b0;
  logic [7:0]  row_addr = '0;
  logic [5:0]  col_addr = '0;
  logic        test_done = 1'b0;
  logic        done, repairable;
  logic [3:0]  srow_valid;
  logic [31:0] srow_addr;
  logic [1:0]  scol_valid;
  logic [7:0]  scol_addr;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  pivot_redund_alloc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fault_valid(fault_valid),
    .row_addr(row_addr), .col_addr(col_addr), .test_done(test_done),
    .done(done), .repairable(repairable), .srow_valid(srow_valid),
    .srow_addr(srow_addr), .scol_valid(scol_valid), .scol_addr(scol_addr)
  );

  localparam int NV = 11;
  localparam int NF [NV] = '{1, 3, 3, 6, 5, 6, 2, 3, 8, 10, 10};
  localparam logic [7:0] FR [NV][10] = '{
    '{8'h10, 0, 0, 0, 0, 0, 0, 0, 0, 0},
    '{8'h20, 8'h20, 8'h20, 0, 0, 0, 0, 0, 0, 0},
    '{1, 2, 3, 0, 0, 0, 0, 0, 0, 0},
    '{1, 2, 3, 4, 5, 6, 0, 0, 0, 0},
    '{7, 7, 9, 10, 11, 0, 0, 0, 0, 0},
    '{1, 2, 3, 4, 5, 6, 0, 0, 0, 0},
    '{5, 5, 0, 0, 0, 0, 0, 0, 0, 0},
    '{1, 2, 1, 0, 0, 0, 0, 0, 0, 0},
    '{1, 1, 2, 2, 3, 3, 4, 4, 0, 0},
    '{1, 1, 2, 2, 3, 3, 4, 4, 5, 5},
    '{1, 1, 9, 2, 2, 10, 3, 4, 5, 6}};
  localparam logic [5:0] FC [NV][10] = '{
    '{5, 0, 0, 0, 0, 0, 0, 0, 0, 0},
    '{1, 9, 17, 0, 0, 0, 0, 0, 0, 0},
    '{8, 9, 10, 0, 0, 0, 0, 0, 0, 0},
    '{0, 4, 8, 12, 16, 20, 0, 0, 0, 0},
    '{0, 4, 12, 13, 20, 0, 0, 0, 0, 0},
    '{0, 1, 4, 5, 8, 9, 0, 0, 0, 0},
    '{5, 6, 0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 4, 5, 0, 0, 0, 0, 0, 0, 0},
    '{0, 4, 8, 12, 16, 20, 24, 28, 0, 0},
    '{0, 4, 8, 12, 16, 20, 24, 28, 32, 36},
    '{0, 4, 1, 8, 12, 9, 16, 20, 24, 28}};
  localparam logic       EREP [NV] = '{1, 1, 1, 1, 1, 0, 1, 1, 1, 0, 0};
  localparam logic [3:0] ERV  [NV] = '{4'b0001, 4'b0001, 4'b0000, 4'b1111, 4'b0011,
                                       4'b0000, 4'b0001, 4'b0001, 4'b1111, 4'b1111, 4'b1111};
  localparam logic [7:0] ERA  [NV][4] = '{
    '{8'h10, 0, 0, 0}, '{8'h20, 0, 0, 0}, '{0, 0, 0, 0}, '{1, 2, 3, 4},
    '{7, 11, 0, 0}, '{0, 0, 0, 0}, '{5, 0, 0, 0}, '{1, 0, 0, 0},
    '{1, 2, 3, 4}, '{1, 2, 3, 4}, '{1, 2, 3, 4}};
  localparam logic [1:0] ECV  [NV] = '{2'b00, 2'b00, 2'b01, 2'b11, 2'b01,
                                       2'b11, 2'b00, 2'b01, 2'b00, 2'b00, 2'b11};
  localparam logic [3:0] ECA  [NV][2] = '{
    '{0, 0}, '{0, 0}, '{2, 0}, '{4, 5}, '{3, 0}, '{0, 1},
    '{0, 0}, '{1, 0}, '{0, 0}, '{0, 0}, '{0, 2}};

  function automatic string vtag(input int v);
    case (v)
      0: return "R9 single orthogonal";
      1: return "R3 shared row";
      2: return "R4 shared column group";
      3: return "R9 R2 six orthogonal";
      4: return "R7 mixed essentials";
      5: return "R8 too many column-essential";
      6: return "R5 duplicate cell";
      7: return "R2 cross match";
      8: return "R3 all spare rows";
      9: return "R8 too many row-essential";
      default: return "R9 orthogonal exhausted";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc;
    @(negedge clk);
  endtask

  task automatic pulse_start;
    start = 1'b1;
    cyc();
    start = 1'b0;
  endtask

  task automatic feed(input logic [7:0] r, input logic [5:0] c, input logic td);
    fault_valid = 1'b1;
    row_addr = r;
    col_addr = c;
    test_done = td;
    cyc();
    fault_valid = 1'b0;
    test_done = 1'b0;
  endtask

  task automatic end_test;
    test_done = 1'b1;
    cyc();
    test_done = 1'b0;
  endtask

  task automatic wait_done;
    for (int k = 0; k < 60 && !done; k++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    cyc(); cyc();
    // R1: reset state
    chk("R1 reset done", {31'd0, done}, 0);
    chk("R1 reset repairable", {31'd0, repairable}, 0);
    chk("R1 reset valids", {26'd0, scol_valid, srow_valid}, 0);
    rst_n = 1'b1;
    cyc();
    // R1: strobes before first start are ignored
    feed(8'h44, 6'd3, 1'b1);
    cyc();
    chk("R1 idle ignores test_done", {31'd0, done}, 0);
    pulse_start();
    end_test();
    wait_done();
    chk("R1 empty run done", {31'd0, done}, 1);
    chk("R1 idle fault ignored rep", {31'd0, repairable}, 1);
    chk("R1 idle fault ignored valids", {26'd0, scol_valid, srow_valid}, 0);

    for (int v = 0; v < NV; v++) begin
      pulse_start();
      for (int f = 0; f < NF[v]; f++) feed(FR[v][f], FC[v][f], 1'b0);
      end_test();
      wait_done();
      chk({vtag(v), " done"}, {31'd0, done}, 1);
      chk({vtag(v), " repairable"}, {31'd0, repairable}, {31'd0, EREP[v]});
      chk({vtag(v), " row valids"}, {28'd0, srow_valid}, {28'd0, ERV[v]});
      chk({vtag(v), " col valids"}, {30'd0, scol_valid}, {30'd0, ECV[v]});
      for (int k = 0; k < 4; k++)
        if (ERV[v][k]) chk({vtag(v), " row addr"}, {24'd0, srow_addr[k*8 +: 8]}, {24'd0, ERA[v][k]});
      for (int k = 0; k < 2; k++)
        if (ECV[v][k]) chk({vtag(v), " col addr"}, {28'd0, scol_addr[k*4 +: 4]}, {28'd0, ECA[v][k]});
    end

    // R11: results hold while inputs keep moving
    feed(8'h99, 6'd50, 1'b1);
    cyc(); cyc();
    chk("R11 done held", {31'd0, done}, 1);
    chk("R11 row valids held", {28'd0, srow_valid}, 4'b1111);
    chk("R11 row addr held", srow_addr, 32'h04030201);
    chk("R11 col addr held", {24'd0, scol_addr}, 8'h20);
    // R1: start clears result
    pulse_start();
    chk("R1 start clears done", {31'd0, done}, 0);
    chk("R1 start clears valids", {26'd0, scol_valid, srow_valid}, 0);

    // R10: fault together with test_done
    feed(8'h33, 6'd0, 1'b1);
    wait_done();
    chk("R10 same-cycle fault rep", {31'd0, repairable}, 1);
    chk("R10 same-cycle fault row valid", {28'd0, srow_valid}, 4'b0001);
    chk("R10 same-cycle fault row addr", {24'd0, srow_addr[7:0]}, 8'h33);

    // R6: seventh distinct fault, arriving with test_done
    pulse_start();
    for (int f = 0; f < 6; f++) feed(8'(f + 1), 6'(f * 4), 1'b0);
    chk("R6 six entries not done", {31'd0, done}, 0);
    feed(8'd7, 6'd24, 1'b1);
    chk("R6 overflow done next cycle", {31'd0, done}, 1);
    chk("R6 overflow irreparable", {31'd0, repairable}, 0);
    feed(8'd8, 6'd28, 1'b1);
    cyc();
    chk("R6 later input ignored done", {31'd0, done}, 1);
    chk("R6 later input ignored rep", {31'd0, repairable}, 0);
    chk("R6 no spares assigned", {26'd0, scol_valid, srow_valid}, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule